// File: doc/BRIEF.md
# Board Control Register Block

This block is the small register file that sits behind a development board's control window. A host bus presents a 32-bit address and either a write strobe with a 32-bit data word or a read strobe. The block decodes the register offset from the low 20 address bits and updates or returns one register per bus cycle. It holds an 8-bit LED bar value, an eight-character ASCII display buffer, a break/reset byte and a general-purpose output byte. It also holds a set of registers that bit-bang a two-wire serial bus to an attached EEPROM.

Two registers do more than store data. A whole-word display write converts the 32-bit data into eight uppercase hexadecimal characters. A write of one magic value to the soft-reset register produces a single-cycle reset request. The display buffer is presented on a 64-bit output bus. A one-cycle update strobe tells a downstream display driver that the buffer has changed.

Top module: `board_ctrl_regs`

## Requirements
- R1: Only address bits [19:0] select a register, so addresses that differ only in bits [31:20] reach the same register. A read of an offset with no register returns 0. A write to such an offset changes no register and raises no output strobe.
- R2: A read returns its data on `bus_rdata` one clock after the cycle in which `bus_re` is high. `bus_rdata` holds that value until the next read, even if registers change in between.
- R3: Offsets 0x200 and 0x210 always read 0 and ignore writes. Offset 0x208 is read-only and returns 0x12 when parameter `CFG_BIG_END` is 1, or 0x10 when it is 0 (the default).
- R4: Offset 0x408 keeps bits [7:0] of a write, reads them back with the upper bits 0, drives them on `led_bar`, and resets to 0.
- R5: A write to offset 0x410 replaces all eight display characters with the uppercase hex digits ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46) of the data word. Data bits [31:28] go to character 0 and bits [3:0] go to character 7. Character i occupies `disp_chars[8*i+7:8*i]`.
- R6: A write to offset 0x418 + 8*i, for i from 0 to 7, stores data bits [7:0] as character i and leaves the other characters unchanged. Offsets in that range that are not multiples of 8 above 0x418 (for example 0x41C) change nothing.
- R7: After reset every display character is 0x20. `disp_upd` is high for exactly the one cycle after each display write (R5 or R6). The display characters do not change in any cycle where `disp_upd` is low.
- R8: A write of the full word 0x00000042 to offset 0x500 makes `soft_rst_req` high for exactly the one cycle after the write. Any other value, such as 0x43 or 0x142, leaves it low.
- R9: Offset 0x508 keeps 8 bits and resets to 0x0A. Offset 0xA00 keeps 8 bits, resets to 0x00 and drives `gp_out`.
- R10: Offset 0xB10 resets to 0x3 and stores and reads back all 32 bits of a write. Its bit 1 drives `i2c_scl_o` and its bit 0 drives `i2c_sda_o`.
- R11: Offset 0xB18 keeps 1 bit and resets to 1. Offset 0xB08 keeps 2 bits and resets to 0. Offset 0xA08 returns the 0xB10 value while the 0xB18 bit is 1, and returns 0 while it is 0.
- R12: Offset 0xB00 reads as 0x2 with bit 0 replaced by the current `i2c_sda_i` level. Its fixed internal value is 0x3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Bus address; bits [19:0] are decoded |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_re | input | 1 | Read strobe, one read per high cycle |
| bus_rdata | output | 32 | Registered read data |
| led_bar | output | 8 | LED bar register value |
| gp_out | output | 8 | General-purpose output register value |
| disp_chars | output | 64 | Display buffer, character i at bits [8i+7:8i] |
| disp_upd | output | 1 | One-cycle strobe after a display write |
| soft_rst_req | output | 1 | One-cycle soft-reset request |
| i2c_scl_o | output | 1 | Clock line level to the EEPROM |
| i2c_sda_o | output | 1 | Data line level to the EEPROM |
| i2c_sda_i | input | 1 | Data line level read back from the EEPROM |

## Verification
Every result is due exactly one clock after the stimulus cycle. Read data, register outputs, `disp_chars`, `disp_upd` and `soft_rst_req` all come from a single register stage behind the bus strobes. The bench drives each strobe for one cycle starting at a falling edge and samples at the next falling edge, half a period after the registers load. It samples again one cycle later to confirm that the strobes have dropped and that read data has held. The one exception is offset 0xB00: it passes `i2c_sda_i` through the same read register, so its value is fixed at the edge that ends the read cycle.

// File: rtl/bcr_pkg.sv
// Package: shared offsets, reset values and the register-select type
// for the board control register block.
// Assumes a 20-bit decode window; offsets are given within that window.
package bcr_pkg;

    localparam int DEC_W = 20;

    localparam logic [DEC_W-1:0] OFS_SWITCH  = 20'h00200;
    localparam logic [DEC_W-1:0] OFS_STATUS  = 20'h00208;
    localparam logic [DEC_W-1:0] OFS_JUMPER  = 20'h00210;
    localparam logic [DEC_W-1:0] OFS_LED     = 20'h00408;
    localparam logic [DEC_W-1:0] OFS_HEXWORD = 20'h00410;
    localparam logic [DEC_W-1:0] OFS_CHAR0   = 20'h00418;
    localparam logic [DEC_W-1:0] OFS_SOFTRST = 20'h00500;
    localparam logic [DEC_W-1:0] OFS_BRK     = 20'h00508;
    localparam logic [DEC_W-1:0] OFS_GPOUT   = 20'h00A00;
    localparam logic [DEC_W-1:0] OFS_GPIN    = 20'h00A08;
    localparam logic [DEC_W-1:0] OFS_I2CIN   = 20'h00B00;
    localparam logic [DEC_W-1:0] OFS_I2COE   = 20'h00B08;
    localparam logic [DEC_W-1:0] OFS_I2COUT  = 20'h00B10;
    localparam logic [DEC_W-1:0] OFS_I2CSEL  = 20'h00B18;

    localparam int CHAR_STRIDE_LG = 3;

    localparam logic [7:0]  RST_LED    = 8'h00;
    localparam logic [7:0]  RST_BRK    = 8'h0A;
    localparam logic [7:0]  RST_GPOUT  = 8'h00;
    localparam logic [1:0]  RST_I2COE  = 2'b00;
    localparam logic [31:0] RST_I2COUT = 32'h0000_0003;
    localparam logic        RST_I2CSEL = 1'b1;
    localparam logic [31:0] I2CIN_VAL  = 32'h0000_0003;
    localparam logic [31:0] SOFTRST_KEY = 32'h0000_0042;
    localparam logic [7:0]  CHAR_BLANK = 8'h20;
    localparam logic [31:0] STATUS_BE  = 32'h0000_0012;
    localparam logic [31:0] STATUS_LE  = 32'h0000_0010;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SWITCH,
        SEL_STATUS,
        SEL_JUMPER,
        SEL_LED,
        SEL_HEXWORD,
        SEL_CHAR,
        SEL_SOFTRST,
        SEL_BRK,
        SEL_GPOUT,
        SEL_GPIN,
        SEL_I2CIN,
        SEL_I2COE,
        SEL_I2COUT,
        SEL_I2CSEL
    } reg_sel_e;

endpackage

// File: rtl/bcr_addr_decode.sv
// Module: register offset decoder.
// Maps a window offset to a register select, and for the per-character
// display registers also yields the character index.
// Assumes: purely combinational; the caller strips the upper address bits.
module bcr_addr_decode
    import bcr_pkg::*;
#(
    parameter  int NUM_CHARS = 8,
    localparam int IDX_W     = $clog2(NUM_CHARS)
) (
    input  logic [DEC_W-1:0] offset,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] char_idx
);

    localparam logic [DEC_W-1:0] CHAR_LAST =
        OFS_CHAR0 + DEC_W'((NUM_CHARS - 1) << CHAR_STRIDE_LG);

    logic [DEC_W-1:0] char_diff;
    logic             char_hit;

    // Distance from the first character register, used for index and alignment.
    always_comb begin
        char_diff = offset - OFS_CHAR0;
        char_hit  = (offset >= OFS_CHAR0) && (offset <= CHAR_LAST) &&
                    (char_diff[CHAR_STRIDE_LG-1:0] == '0);
        char_idx  = char_diff[CHAR_STRIDE_LG +: IDX_W];
    end

    // Select the one register addressed by the offset.
    always_comb begin
        unique case (offset)
            OFS_SWITCH:  sel = SEL_SWITCH;
            OFS_STATUS:  sel = SEL_STATUS;
            OFS_JUMPER:  sel = SEL_JUMPER;
            OFS_LED:     sel = SEL_LED;
            OFS_HEXWORD: sel = SEL_HEXWORD;
            OFS_SOFTRST: sel = SEL_SOFTRST;
            OFS_BRK:     sel = SEL_BRK;
            OFS_GPOUT:   sel = SEL_GPOUT;
            OFS_GPIN:    sel = SEL_GPIN;
            OFS_I2CIN:   sel = SEL_I2CIN;
            OFS_I2COE:   sel = SEL_I2COE;
            OFS_I2COUT:  sel = SEL_I2COUT;
            OFS_I2CSEL:  sel = SEL_I2CSEL;
            default:     sel = char_hit ? SEL_CHAR : SEL_NONE;
        endcase
    end

endmodule

// File: rtl/bcr_disp_buf.sv
// Module: ASCII display buffer.
// Holds NUM_CHARS characters. A whole-word write expands the data into
// uppercase hex digits, most significant nibble into character 0; a
// character write replaces one character with the data's low byte.
// A one-cycle update strobe follows every write.
// Assumes DATA_W == 4 * NUM_CHARS and that both write inputs are never
// high together (the decoder guarantees it).
module bcr_disp_buf
    import bcr_pkg::*;
#(
    parameter  int NUM_CHARS = 8,
    parameter  int DATA_W    = 32,
    localparam int IDX_W     = $clog2(NUM_CHARS),
    localparam int BUF_W     = 8 * NUM_CHARS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hex,
    input  logic              wr_char,
    input  logic [IDX_W-1:0]  char_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [BUF_W-1:0]  chars_o,
    output logic              upd_o
);

    logic [BUF_W-1:0] hex_img;

    // One hex-to-ASCII converter per display position.
    generate
        for (genvar gi = 0; gi < NUM_CHARS; gi++) begin : g_hex
            logic [3:0] nib;
            assign nib = wdata[DATA_W-1-4*gi -: 4];
            assign hex_img[8*gi +: 8] = (nib < 4'd10) ? (8'h30 + {4'h0, nib})
                                                      : (8'h37 + {4'h0, nib});
        end
    endgenerate

    // Buffer storage and the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chars_o <= {NUM_CHARS{CHAR_BLANK}};
            upd_o   <= 1'b0;
        end else begin
            upd_o <= wr_hex | wr_char;
            if (wr_hex) begin
                chars_o <= hex_img;
            end else if (wr_char) begin
                chars_o[{char_idx, 3'b000} +: 8] <= wdata[7:0];
            end
        end
    end

    AST_DISP_UPD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(wr_hex || wr_char)); // R7
    AST_DISP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(chars_o)); // R7
    AST_DISP_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wr_hex && !wr_char) |-> !upd_o); // R7

endmodule

// File: rtl/bcr_i2c_regs.sv
// Module: bit-banged two-wire bus registers.
// Holds the output register (line levels), output-enable bits and the
// select bit. Bit 1 of the output register is the clock line, bit 0 the
// data line.
// Assumes single-cycle write strobes from the top-level decoder.
module bcr_i2c_regs
    import bcr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_out,
    input  logic              wr_oe,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] out_q,
    output logic [1:0]        oe_q,
    output logic              sel_q,
    output logic              scl_o,
    output logic              sda_o
);

    // Register updates for the three writable bus-control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= DATA_W'(RST_I2COUT);
            oe_q  <= RST_I2COE;
            sel_q <= RST_I2CSEL;
        end else begin
            if (wr_out) out_q <= wdata;
            if (wr_oe)  oe_q  <= wdata[1:0];
            if (wr_sel) sel_q <= wdata[0];
        end
    end

    // Line levels follow the stored output bits.
    assign scl_o = out_q[1];
    assign sda_o = out_q[0];

    AST_LINES_FOLLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_out) |-> (scl_o == $past(wdata[1])) && (sda_o == $past(wdata[0]))); // R10
    AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wr_out) |-> $stable(scl_o) && $stable(sda_o)); // R10

endmodule

// File: rtl/board_ctrl_regs.sv
// Module: board control register block (top).
// Decodes the low 20 address bits, holds the LED, break, general output
// and soft-reset logic, and returns registered read data one cycle after
// a read strobe. Display and two-wire bus registers live in submodules.
// Assumes at most one of bus_we / bus_re per cycle matters for a given
// register; a same-cycle read returns the value before the write.
module board_ctrl_regs
    import bcr_pkg::*;
#(
    parameter  int ADDR_W      = 32,
    parameter  int DATA_W      = 32,
    parameter  int NUM_CHARS   = 8,
    parameter  bit CFG_BIG_END = 1'b0,
    localparam int IDX_W       = $clog2(NUM_CHARS),
    localparam int BUF_W       = 8 * NUM_CHARS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [7:0]        led_bar,
    output logic [7:0]        gp_out,
    output logic [BUF_W-1:0]  disp_chars,
    output logic              disp_upd,
    output logic              soft_rst_req,
    output logic              i2c_scl_o,
    output logic              i2c_sda_o,
    input  logic              i2c_sda_i
);

    reg_sel_e          dec_sel;
    logic [IDX_W-1:0]  dec_idx;
    logic              unused_addr_hi;
    logic [7:0]        brk_q;
    logic [DATA_W-1:0] i2c_out_q;
    logic [1:0]        i2c_oe_q;
    logic              i2c_sel_q;
    logic [DATA_W-1:0] rd_mux;

    assign unused_addr_hi = ^bus_addr[ADDR_W-1:DEC_W];

    bcr_addr_decode #(
        .NUM_CHARS (NUM_CHARS)
    ) i_dec (
        .offset   (bus_addr[DEC_W-1:0]),
        .sel      (dec_sel),
        .char_idx (dec_idx)
    );

    bcr_disp_buf #(
        .NUM_CHARS (NUM_CHARS),
        .DATA_W    (DATA_W)
    ) i_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hex   (bus_we && (dec_sel == SEL_HEXWORD)),
        .wr_char  (bus_we && (dec_sel == SEL_CHAR)),
        .char_idx (dec_idx),
        .wdata    (bus_wdata),
        .chars_o  (disp_chars),
        .upd_o    (disp_upd)
    );

    bcr_i2c_regs #(
        .DATA_W (DATA_W)
    ) i_i2c (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_out (bus_we && (dec_sel == SEL_I2COUT)),
        .wr_oe  (bus_we && (dec_sel == SEL_I2COE)),
        .wr_sel (bus_we && (dec_sel == SEL_I2CSEL)),
        .wdata  (bus_wdata),
        .out_q  (i2c_out_q),
        .oe_q   (i2c_oe_q),
        .sel_q  (i2c_sel_q),
        .scl_o  (i2c_scl_o),
        .sda_o  (i2c_sda_o)
    );

    // Byte-wide board registers and the soft-reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_bar      <= RST_LED;
            brk_q        <= RST_BRK;
            gp_out       <= RST_GPOUT;
            soft_rst_req <= 1'b0;
        end else begin
            soft_rst_req <= bus_we && (dec_sel == SEL_SOFTRST) &&
                            (bus_wdata == DATA_W'(SOFTRST_KEY));
            if (bus_we && (dec_sel == SEL_LED))   led_bar <= bus_wdata[7:0];
            if (bus_we && (dec_sel == SEL_BRK))   brk_q   <= bus_wdata[7:0];
            if (bus_we && (dec_sel == SEL_GPOUT)) gp_out  <= bus_wdata[7:0];
        end
    end

    // Read-data selection for the addressed register.
    always_comb begin
        rd_mux = '0;
        unique case (dec_sel)
            SEL_STATUS:  rd_mux = CFG_BIG_END ? DATA_W'(STATUS_BE) : DATA_W'(STATUS_LE);
            SEL_LED:     rd_mux = DATA_W'(led_bar);
            SEL_BRK:     rd_mux = DATA_W'(brk_q);
            SEL_GPOUT:   rd_mux = DATA_W'(gp_out);
            SEL_GPIN:    rd_mux = i2c_sel_q ? i2c_out_q : '0;
            SEL_I2CIN:   rd_mux = {I2CIN_VAL[DATA_W-1:1], i2c_sda_i};
            SEL_I2COE:   rd_mux = DATA_W'(i2c_oe_q);
            SEL_I2COUT:  rd_mux = i2c_out_q;
            SEL_I2CSEL:  rd_mux = DATA_W'(i2c_sel_q);
            default:     rd_mux = '0;
        endcase
    end

    // Read data register: loads on a read strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_mux;
        end
    end

    AST_SOFTRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> $past(bus_we && (bus_addr[DEC_W-1:0] == OFS_SOFTRST) &&
                               (bus_wdata == DATA_W'(SOFTRST_KEY)))); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_re && (dec_sel == SEL_NONE)) |-> (bus_rdata == '0)); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bus_re) |-> $stable(bus_rdata)); // R2
    AST_GPIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_re && (dec_sel == SEL_GPIN) && !i2c_sel_q) |-> (bus_rdata == '0)); // R11

endmodule

// File: tb/test_board_ctrl_regs.sv
module test_board_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  led_bar;
    logic [7:0]  gp_out;
    logic [63:0] disp_chars;
    logic        disp_upd;
    logic        soft_rst_req;
    logic        i2c_scl_o;
    logic        i2c_sda_o;
    logic        i2c_sda_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    board_ctrl_regs i_board_ctrl_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_we       (bus_we),
        .bus_re       (bus_re),
        .bus_rdata    (bus_rdata),
        .led_bar      (led_bar),
        .gp_out       (gp_out),
        .disp_chars   (disp_chars),
        .disp_upd     (disp_upd),
        .soft_rst_req (soft_rst_req),
        .i2c_scl_o    (i2c_scl_o),
        .i2c_sda_o    (i2c_sda_o),
        .i2c_sda_i    (i2c_sda_i)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Pack an 8-character string, character 0 into bits [7:0].
    function automatic logic [63:0] pack8(input string s);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = s[i];
        return v;
    endfunction

    // One write cycle; returns at the falling edge after the loading edge.
    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R4 led reset", {56'h0, led_bar}, 64'h0);
        chk("R9 gp_out reset", {56'h0, gp_out}, 64'h0);
        chk("R7 display reset", disp_chars, pack8("        "));
        chk("R7 no strobe at reset", {63'h0, disp_upd}, 64'h0);
        chk("R8 no soft reset at reset", {63'h0, soft_rst_req}, 64'h0);
        chk("R10 lines reset", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h3);
        bus_read(32'h508, d); chk("R9 brk reset", {32'h0, d}, 64'h0A);
        bus_read(32'hB10, d); chk("R10 i2c out reset", {32'h0, d}, 64'h3);
        bus_read(32'hB08, d); chk("R11 oe reset", {32'h0, d}, 64'h0);
        bus_read(32'hB18, d); chk("R11 sel reset", {32'h0, d}, 64'h1);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        bus_write(32'hFFF0_0408, 32'h0000_005A);
        chk("R1 alias write", {56'h0, led_bar}, 64'h5A);
        bus_read(32'h1230_0408, d); chk("R1 alias read", {32'h0, d}, 64'h5A);
        bus_write(32'h0000_0404, 32'hFFFF_FFFF);
        chk("R1 unmapped write no strobe", {62'h0, disp_upd, soft_rst_req}, 64'h0);
        chk("R1 unmapped write led", {56'h0, led_bar}, 64'h5A);
        chk("R1 unmapped write display", disp_chars, pack8("        "));
        bus_read(32'h404, d); chk("R1 unmapped read", {32'h0, d}, 64'h0);
    endtask

    task automatic t_readhold();
        logic [31:0] d;
        bus_read(32'h408, d);
        bus_write(32'h408, 32'h0000_00C3);
        chk("R2 rdata holds", {32'h0, bus_rdata}, {32'h0, d});
        bus_read(32'h408, d); chk("R2 new read", {32'h0, d}, 64'hC3);
        chk("R4 led output", {56'h0, led_bar}, 64'hC3);
        bus_write(32'h408, 32'h1234_5677);
        bus_read(32'h408, d); chk("R4 led low byte only", {32'h0, d}, 64'h77);
    endtask

    task automatic t_fixed();
        logic [31:0] d;
        bus_write(32'h200, 32'hFFFF_FFFF);
        bus_write(32'h210, 32'hFFFF_FFFF);
        bus_write(32'h208, 32'hFFFF_FFFF);
        bus_read(32'h200, d); chk("R3 switch", {32'h0, d}, 64'h0);
        bus_read(32'h210, d); chk("R3 jumper", {32'h0, d}, 64'h0);
        bus_read(32'h208, d); chk("R3 status", {32'h0, d}, 64'h10);
    endtask

    task automatic t_hexword();
        bus_write(32'h410, 32'h1234_ABCD);
        chk("R5 hex expand", disp_chars, pack8("1234ABCD"));
        chk("R7 strobe after hex", {63'h0, disp_upd}, 64'h1);
        @(negedge clk);
        chk("R7 strobe one cycle", {63'h0, disp_upd}, 64'h0);
        bus_write(32'h410, 32'hF09E_5C60);
        chk("R5 hex second pattern", disp_chars, pack8("F09E5C60"));
    endtask

    task automatic t_chars();
        logic [63:0] e;
        e = pack8("F09E5C60");
        bus_write(32'h418, 32'hFFFF_FF41);
        e[7:0] = 8'h41;
        chk("R6 char 0", disp_chars, e);
        chk("R7 strobe after char", {63'h0, disp_upd}, 64'h1);
        bus_write(32'h450, 32'h0000_007A);
        e[63:56] = 8'h7A;
        chk("R6 char 7", disp_chars, e);
        bus_write(32'h430, 32'h0000_0021);
        e[31:24] = 8'h21;
        chk("R6 char 3", disp_chars, e);
        bus_write(32'h41C, 32'h0000_0055);
        chk("R6 misaligned ignored", disp_chars, e);
        chk("R6 misaligned no strobe", {63'h0, disp_upd}, 64'h0);
        bus_write(32'h458, 32'h0000_0055);
        chk("R6 past last ignored", disp_chars, e);
    endtask

    task automatic t_softrst();
        bus_write(32'h500, 32'h0000_0042);
        chk("R8 pulse", {63'h0, soft_rst_req}, 64'h1);
        @(negedge clk);
        chk("R8 pulse one cycle", {63'h0, soft_rst_req}, 64'h0);
        bus_write(32'h500, 32'h0000_0043);
        chk("R8 other value", {63'h0, soft_rst_req}, 64'h0);
        bus_write(32'h500, 32'h0000_0142);
        chk("R8 full word compare", {63'h0, soft_rst_req}, 64'h0);
    endtask

    task automatic t_bytes();
        logic [31:0] d;
        bus_write(32'h508, 32'hABCD_EF96);
        bus_read(32'h508, d); chk("R9 brk", {32'h0, d}, 64'h96);
        bus_write(32'hA00, 32'h0000_1E3C);
        chk("R9 gp_out", {56'h0, gp_out}, 64'h3C);
        bus_read(32'hA00, d); chk("R9 gp read", {32'h0, d}, 64'h3C);
    endtask

    task automatic t_i2c();
        logic [31:0] d;
        bus_write(32'hB10, 32'hDEAD_BEE2);
        chk("R10 scl/sda", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h2);
        bus_read(32'hB10, d); chk("R10 full store", {32'h0, d}, 64'hDEADBEE2);
        bus_write(32'hB10, 32'h0000_0001);
        chk("R10 sda only", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h1);
        bus_read(32'hA08, d); chk("R11 gpin selected", {32'h0, d}, 64'h1);
        bus_write(32'hB18, 32'hFFFF_FFFE);
        bus_read(32'hB18, d); chk("R11 sel cleared", {32'h0, d}, 64'h0);
        bus_read(32'hA08, d); chk("R11 gpin gated", {32'h0, d}, 64'h0);
        bus_write(32'hB08, 32'hFFFF_FFFF);
        bus_read(32'hB08, d); chk("R11 oe two bits", {32'h0, d}, 64'h3);
        i2c_sda_i = 1'b1;
        bus_read(32'hB00, d); chk("R12 sda high", {32'h0, d}, 64'h3);
        i2c_sda_i = 1'b0;
        bus_read(32'hB00, d); chk("R12 sda low", {32'h0, d}, 64'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_readhold();
        t_fixed();
        t_hexword();
        t_chars();
        t_softrst();
        t_bytes();
        t_i2c();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule